// File: doc/BRIEF.md
# Dual-Clock Buffer Queue with Selectable Read Timing

This block is an 18-bit first-in first-out buffer whose write and read sides each run on their own clock. The two clocks may be one net or may be unrelated. A write clock edge with the write enable high stores one word unless the buffer is full. On the read side, a static mode input picks one of two timings. In standard timing a word is presented only when a read is requested. In fall-through timing the oldest word moves to the output register by itself. The two status flags change meaning with the mode.

Almost-empty and almost-full thresholds can be programmed and come up as 7 after reset. New values are written through the write port while a load input is held high, one threshold per enabled write edge. A half-full flag reports a fill above half the depth. An output enable forces the read data to zero and drops a valid qualifier. The block does not drive a high-impedance bus. Pointers cross between the clocks in Gray code through two-flop synchronizers.

Top module: `dcFifo`

## Requirements
- R1: An enabled write edge with `loadEn` low stores `wrData` when the buffer is not full. A write attempted while full is dropped and leaves the stored words unchanged.
- R2: With `fwftMode`=0, a written word does not reach `rdData` by itself. Each read edge with `rdEn` high and the buffer not empty loads the oldest stored word into `rdData`, in write order.
- R3: With `fwftMode`=1, a word written into an empty buffer reaches `rdData` on the third read-clock edge after its write edge, without `rdEn`. `readFlag` goes high on that same edge and stays high until an edge with `rdEn` high consumes the word.
- R4: With `fwftMode`=0, `readFlag`=1 means empty and `writeFlag`=1 means full. With `fwftMode`=1, `readFlag`=1 means a word is waiting on `rdData` and `writeFlag`=1 means another write will be accepted. In that mode the buffer holds DEPTH+1 words, because the output register also holds one.
- R5: In standard timing, a read request while empty is ignored: `rdData` keeps its value and the read pointer does not move.
- R6: After reset both thresholds are 7. `almostEmpty` is high when the stored count is at most the almost-empty threshold. `almostFull` is high when the free space (DEPTH minus count) is at most the almost-full threshold.
- R7: While `loadEn` is high, each enabled write edge stores `wrData[log2(DEPTH)-1:0]` into a threshold instead of the buffer. The targets alternate almost-empty, almost-full, almost-empty, and so on.
- R8: `halfFull` is high when the count seen on the write side is greater than DEPTH/2.
- R9: While `outEn` is low, `rdData` is zero and `rdValid` is low. Raising `outEn` again shows the held word.
- R10: An empty flag clears two read-clock edges after the write edge. A full flag clears two write-clock edges after the read edge.
- R11: Reset is asynchronous and active low. After reset in standard timing: `readFlag`=1, `writeFlag`=0, `almostEmpty`=1, `almostFull`=0, `halfFull`=0, `rdValid`=0, `rdData`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fwftMode | input | 1 | 0 = standard timing, 1 = fall-through timing (static) |
| wrEn | input | 1 | Write enable |
| wrData | input | 18 | Write data, or threshold value while loading |
| loadEn | input | 1 | Routes enabled writes to the threshold registers |
| rdEn | input | 1 | Read enable |
| outEn | input | 1 | Output enable; low forces data to zero |
| rdData | output | 18 | Read data |
| rdValid | output | 1 | A word is held on `rdData` and output is enabled |
| readFlag | output | 1 | Empty (standard) or output-ready (fall-through) |
| writeFlag | output | 1 | Full (standard) or input-ready (fall-through) |
| almostEmpty | output | 1 | Count at or below the almost-empty threshold |
| almostFull | output | 1 | Free space at or below the almost-full threshold |
| halfFull | output | 1 | Count above half the depth |

## Verification
The bench fills the buffer to exactly full and then writes once more. If full detection were off by one, a stray word would appear, or one would be missing, when the buffer is drained. It probes each threshold at count N and N+1, so a comparison using `<` instead of `<=` would flip a flag one word early or late. It times the first fall-through word and the clearing of the empty and full flags edge by edge. A missing or extra synchronizer stage would move those edges. It also loads three thresholds in a row to prove the load order wraps. Randomized traffic in both modes catches ordering errors when reads and writes coincide.

// File: rtl/fifoPkg.sv
package fifoPkg;
  localparam int DATA_W = 18;
  localparam int DEFAULT_OFFSET = 7;

  typedef logic [DATA_W-1:0] word_t;

  // strobes issued by the control unit to the datapath
  typedef struct packed {
    logic memWrite;  // write clock domain: store wrData
    logic outLoad;   // read clock domain: move a stored word to output
    logic aeLoad;    // write clock domain: load almost-empty threshold
    logic afLoad;    // write clock domain: load almost-full threshold
  } strobe_t;
endpackage

// File: rtl/ptrSync.sv
module ptrSync #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] grayIn,
  output logic [PW-1:0] binOut
);
  logic [PW-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits
  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign binOut[i] = ^stage2[PW-1:i];
  end
endmodule

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import fifoPkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW = $clog2(DEPTH),
  parameter int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          fwftMode,
  input  logic          wrEn,
  input  logic          loadEn,
  input  logic          rdEn,
  input  logic          outEn,
  input  logic [AW-1:0] aeOffset,
  input  logic [AW-1:0] afOffset,
  output strobe_t       strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          readFlag,
  output logic          writeFlag,
  output logic          almostEmpty,
  output logic          almostFull,
  output logic          halfFull,
  output logic          rdValid
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  // ---------------- write clock domain ----------------
  logic [PW-1:0] wrPtr, wrGray, wrNext, rdPtrW, wCount, freeSpace;
  logic fullNow, doWrite, doLoad, loadSel;

  assign wCount    = wrPtr - rdPtrW;
  assign fullNow   = (wCount == DEPTH_P);
  assign freeSpace = DEPTH_P - wCount;
  assign doWrite   = wrEn && !loadEn && !fullNow;
  assign doLoad    = wrEn && loadEn;
  assign wrNext    = wrPtr + PW'(1);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      wrGray  <= '0;
      loadSel <= 1'b0;
    end else begin
      if (doWrite) begin
        wrPtr  <= wrNext;
        wrGray <= wrNext ^ (wrNext >> 1);
      end
      if (doLoad) loadSel <= !loadSel;
    end
  end

  // ---------------- read clock domain ----------------
  logic [PW-1:0] rdPtr, rdGray, rdNext, wrPtrR, memCount;
  logic [PW:0]   rCount;
  logic memEmpty, outLoad, outValid;

  assign memCount = wrPtrR - rdPtr;
  assign memEmpty = (memCount == '0);
  assign rdNext   = rdPtr + PW'(1);
  assign outLoad  = fwftMode ? (!memEmpty && (!outValid || rdEn))
                             : (rdEn && !memEmpty);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      if (outLoad) begin
        rdPtr    <= rdNext;
        rdGray   <= rdNext ^ (rdNext >> 1);
        outValid <= 1'b1;
      end else if (fwftMode && rdEn) begin
        outValid <= 1'b0;
      end
    end
  end

  // ---------------- pointer crossings ----------------
  ptrSync #(.PW(PW)) rdToWr_i (
    .clk(wrClk), .rstN(rstN), .grayIn(rdGray), .binOut(rdPtrW)
  );
  ptrSync #(.PW(PW)) wrToRd_i (
    .clk(rdClk), .rstN(rstN), .grayIn(wrGray), .binOut(wrPtrR)
  );

  // ---------------- flags and strobes ----------------
  assign rCount      = {1'b0, memCount} + (PW+1)'(fwftMode && outValid);
  assign almostEmpty = (rCount <= (PW+1)'(aeOffset));
  assign almostFull  = (freeSpace <= PW'(afOffset));
  assign halfFull    = (wCount > HALF_P);
  assign readFlag    = fwftMode ? outValid : memEmpty;
  assign writeFlag   = fwftMode ? !fullNow : fullNow;
  assign rdValid     = outEn && outValid;

  assign wrAddr        = wrPtr[AW-1:0];
  assign rdAddr        = rdPtr[AW-1:0];
  assign strb.memWrite = doWrite;
  assign strb.outLoad  = outLoad;
  assign strb.aeLoad   = doLoad && !loadSel;
  assign strb.afLoad   = doLoad && loadSel;
endmodule

// File: rtl/fifoData.sv
module fifoData
  import fifoPkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  word_t         wrData,
  input  logic          outEn,
  output word_t         rdData,
  output logic [AW-1:0] aeOffset,
  output logic [AW-1:0] afOffset
);
  word_t store [DEPTH];
  word_t outReg;

  always_ff @(posedge wrClk) begin
    if (strb.memWrite) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)            outReg <= '0;
    else if (strb.outLoad) outReg <= store[rdAddr];
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOffset <= AW'(DEFAULT_OFFSET);
      afOffset <= AW'(DEFAULT_OFFSET);
    end else begin
      if (strb.aeLoad) aeOffset <= wrData[AW-1:0];
      if (strb.afLoad) afOffset <= wrData[AW-1:0];
    end
  end

  assign rdData = outEn ? outReg : '0;
endmodule

// File: rtl/dcFifo.sv
module dcFifo
  import fifoPkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic        fwftMode,
  input  logic        wrEn,
  input  logic [17:0] wrData,
  input  logic        loadEn,
  input  logic        rdEn,
  input  logic        outEn,
  output logic [17:0] rdData,
  output logic        rdValid,
  output logic        readFlag,
  output logic        writeFlag,
  output logic        almostEmpty,
  output logic        almostFull,
  output logic        halfFull
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  strobe_t       strb;
  logic [AW-1:0] wrAddr, rdAddr, aeOffset, afOffset;

  fifoCtrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
    .wrEn(wrEn), .loadEn(loadEn), .rdEn(rdEn), .outEn(outEn),
    .aeOffset(aeOffset), .afOffset(afOffset), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .readFlag(readFlag),
    .writeFlag(writeFlag), .almostEmpty(almostEmpty),
    .almostFull(almostFull), .halfFull(halfFull), .rdValid(rdValid)
  );

  fifoData #(.DEPTH(DEPTH), .AW(AW)) data_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .outEn(outEn),
    .rdData(rdData), .aeOffset(aeOffset), .afOffset(afOffset)
  );
endmodule

// File: rtl/fifoChecker.sv
module fifoChecker #(
  parameter int AW = 8
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          fwftMode,
  input logic          wrEn,
  input logic          loadEn,
  input logic          rdEn,
  input logic          outEn,
  input logic [17:0]   rdData,
  input logic          rdValid,
  input logic          readFlag,
  input logic          writeFlag,
  input logic          almostFull,
  input logic          halfFull,
  input logic [AW-1:0] wrAddr,
  input logic [AW-1:0] rdAddr
);
  // a write attempted while full must not advance the write address
  assert_no_overflow_R1: assert property (@(posedge wrClk) disable iff (!rstN)
    (!fwftMode && writeFlag && wrEn) |=> $stable(wrAddr));

  // a threshold load never advances the write address
  assert_load_no_store_R7: assert property (@(posedge wrClk) disable iff (!rstN)
    (loadEn && wrEn) |=> $stable(wrAddr));

  // full implies more than half full
  assert_full_half_R8: assert property (@(posedge wrClk) disable iff (!rstN)
    (!fwftMode && writeFlag) |-> halfFull);

  // full implies almost full for any threshold
  assert_full_almost_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    (!fwftMode && writeFlag) |-> almostFull);

  // a read request while empty leaves the read address alone
  assert_no_underflow_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && readFlag) |=> $stable(rdAddr));

  // a ready word stays until it is consumed
  assert_ready_hold_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && readFlag && !rdEn) |=> readFlag);

  // output enable low gates data and valid
  assert_oe_gate_R9: assert property (@(posedge rdClk) disable iff (!rstN)
    !outEn |-> (rdData == '0 && !rdValid));
endmodule

bind dcFifo fifoChecker #(.AW(AW)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
  .wrEn(wrEn), .loadEn(loadEn), .rdEn(rdEn), .outEn(outEn),
  .rdData(rdData), .rdValid(rdValid), .readFlag(readFlag),
  .writeFlag(writeFlag), .almostFull(almostFull), .halfFull(halfFull),
  .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/dcFifo_tb_top.sv
module dcFifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, fwftMode, wrEn, loadEn, rdEn, outEn;
  logic [17:0] wrData, rdData;
  logic rdValid, readFlag, writeFlag, almostEmpty, almostFull, halfFull;

  dcFifo #(.DEPTH(DEPTH)) dut_i (
    .wrClk(clk), .rdClk(clk), .rstN(rstN), .fwftMode(fwftMode),
    .wrEn(wrEn), .wrData(wrData), .loadEn(loadEn), .rdEn(rdEn),
    .outEn(outEn), .rdData(rdData), .rdValid(rdValid),
    .readFlag(readFlag), .writeFlag(writeFlag), .almostEmpty(almostEmpty),
    .almostFull(almostFull), .halfFull(halfFull)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expAe(int cnt, int off); return int'(cnt <= off); endfunction
  function automatic int expAf(int cnt, int off); return int'((DEPTH - cnt) <= off); endfunction
  function automatic int expHf(int cnt); return int'(cnt > DEPTH / 2); endfunction

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(int n); repeat (n) step(); endtask

  task automatic startUp(input bit mode);
    rstN = 1'b0; wrEn = 0; rdEn = 0; loadEn = 0; outEn = 1; wrData = '0;
    fwftMode = mode;
    idle(2);
    rstN = 1'b1;
    step();
  endtask

  task automatic putWord(input logic [17:0] d);
    wrEn = 1; wrData = d; step(); wrEn = 0;
  endtask

  task automatic getWord();
    rdEn = 1; step(); rdEn = 0;
  endtask

  task automatic runRandom(input bit mode, input int cycles);
    logic [17:0] q[$];
    logic [17:0] expd;
    bit pend;
    startUp(mode);
    pend = 0;
    for (int c = 0; c < cycles; c++) begin
      bit doW, doR;
      int wBias;
      wBias = (c < cycles / 2) ? 70 : 30;
      doW = (($urandom % 100) < wBias) && (mode ? writeFlag : !writeFlag);
      doR = (($urandom % 100) < (100 - wBias)) && (mode ? readFlag : !readFlag);
      if (doR) begin
        if (q.size() == 0) chk("R2/R3 read with nothing expected", 1, 0);
        else if (mode) begin
          chk("R3 fall-through order", int'(rdData), int'(q[0]));
          void'(q.pop_front());
        end else begin
          expd = q.pop_front();
          pend = 1;
        end
      end
      wrEn = doW; rdEn = doR;
      wrData = 18'($urandom);
      if (doW) q.push_back(wrData);
      step();
      if (pend) begin
        chk("R2 standard order", int'(rdData), int'(expd));
        pend = 0;
      end
    end
    wrEn = 0; rdEn = 0;
  endtask

  initial begin
    int acc;
    void'($urandom(32'h5eed_1234));

    // ---------- standard timing ----------
    startUp(1'b0);
    chk("R11 readFlag", readFlag, 1);
    chk("R11 writeFlag", writeFlag, 0);
    chk("R11 almostEmpty", almostEmpty, 1);
    chk("R11 almostFull", almostFull, 0);
    chk("R11 halfFull", halfFull, 0);
    chk("R11 rdValid", rdValid, 0);
    chk("R11 rdData", int'(rdData), 0);

    getWord();  // read while empty
    chk("R5 empty read data", int'(rdData), 0);
    chk("R5 empty read valid", rdValid, 0);

    putWord(18'h155);
    chk("R10 empty after write edge", readFlag, 1);
    step();
    chk("R10 empty one edge later", readFlag, 1);
    step();
    chk("R10 empty clears at second edge", readFlag, 0);
    chk("R2 no word without read", int'(rdData), 0);
    getWord();
    chk("R2 first read data", int'(rdData), 'h155);
    chk("R2 first read valid", rdValid, 1);
    chk("R5 R4 empty after draining", readFlag, 1);
    getWord();
    chk("R5 data held on empty read", int'(rdData), 'h155);

    for (int i = 0; i < 7; i++) putWord(18'(32'h100 + i));
    idle(4);
    chk("R6 almostEmpty at 7", almostEmpty, expAe(7, 7));
    putWord(18'h107);
    idle(4);
    chk("R6 almostEmpty at 8", almostEmpty, expAe(8, 7));
    for (int i = 0; i < 8; i++) begin
      getWord();
      chk("R2 ordered read", int'(rdData), 'h100 + i);
    end

    // fill to full
    for (int i = 0; i < DEPTH; i++) begin
      putWord(18'(i));
      if (i + 1 == DEPTH / 2 || i + 1 == DEPTH / 2 + 1) begin
        idle(4); chk("R8 halfFull", halfFull, expHf(i + 1));
      end
      if (i + 1 == DEPTH - 8 || i + 1 == DEPTH - 7) begin
        idle(4); chk("R6 almostFull", almostFull, expAf(i + 1, 7));
      end
    end
    idle(4);
    chk("R4 full flag", writeFlag, 1);
    putWord(18'h3ffff);  // dropped
    getWord();
    chk("R1 first word after fill", int'(rdData), 0);
    chk("R10 full holds at read edge", writeFlag, 1);
    step();
    chk("R10 full holds one edge later", writeFlag, 1);
    step();
    chk("R10 full clears at second edge", writeFlag, 0);
    for (int i = 1; i < DEPTH; i++) begin
      getWord();
      chk("R1 drained word", int'(rdData), i);
    end
    idle(4);
    chk("R1 extra write dropped", readFlag, 1);

    putWord(18'h2aaaa);
    idle(3);
    getWord();
    chk("R9 word before gating", int'(rdData), 'h2aaaa);
    outEn = 0; #1;
    chk("R9 data gated", int'(rdData), 0);
    chk("R9 valid gated", rdValid, 0);
    outEn = 1; #1;
    chk("R9 data restored", int'(rdData), 'h2aaaa);
    chk("R9 valid restored", rdValid, 1);

    // ---------- threshold load ----------
    startUp(1'b0);
    loadEn = 1;
    putWord(18'd5); putWord(18'd10); putWord(18'd2);
    loadEn = 0;
    idle(4);
    chk("R7 loads store no words", readFlag, 1);
    putWord(18'h1); putWord(18'h2);
    idle(4);
    chk("R7 wrapped threshold at 2", almostEmpty, expAe(2, 2));
    putWord(18'h3);
    idle(4);
    chk("R7 wrapped threshold at 3", almostEmpty, expAe(3, 2));
    for (int i = 3; i < DEPTH - 11; i++) putWord(18'(i));
    idle(4);
    chk("R7 almostFull threshold 10 at 245", almostFull, expAf(DEPTH - 11, 10));
    putWord(18'h0);
    idle(4);
    chk("R7 almostFull threshold 10 at 246", almostFull, expAf(DEPTH - 10, 10));

    // ---------- fall-through timing ----------
    startUp(1'b1);
    chk("R4 ready low after reset", readFlag, 0);
    chk("R4 input ready after reset", writeFlag, 1);
    putWord(18'h12345);
    chk("R3 not ready at write edge", readFlag, 0);
    step();
    chk("R3 not ready edge 1", readFlag, 0);
    step();
    chk("R3 not ready edge 2", readFlag, 0);
    step();
    chk("R3 ready at edge 3", readFlag, 1);
    chk("R3 word fell through", int'(rdData), 'h12345);
    chk("R3 valid", rdValid, 1);
    idle(3);
    chk("R3 ready holds", readFlag, 1);
    getWord();
    chk("R3 ready drops after consume", readFlag, 0);

    acc = 0;
    for (int i = 0; i < 300; i++) begin
      if (writeFlag) begin putWord(18'(acc)); acc++; end
      else step();
    end
    idle(4);
    chk("R4 fall-through capacity", acc, DEPTH + 1);
    chk("R4 input ready low", writeFlag, 0);
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R4 fall-through drain", int'(rdData), i);
      getWord();
    end
    chk("R4 not ready after drain", readFlag, 0);

    // ---------- random traffic ----------
    runRandom(1'b0, 4000);
    runRandom(1'b1, 4000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule